// File: doc/BRIEF.md
# Power Stage Fault Supervisor

This block sits between the comparator outputs of a synchronous buck power stage and its gate drivers. It turns protection comparator bits into gate override signals and a single open-style status flag. A positive over-current trip, once it has lasted through a blanking filter, forces the high side off for the rest of the switching cycle. A trip that repeats over many back-to-back cycles raises the flag. A negative over-current trip truncates the low-side on-time for a fixed window or until the PWM input asks for the high side again.

An over-temperature warning with separate set and clear thresholds also raises the flag, while switching carries on. The flag is held low until the power-up ready signal is true, so a low flag also means "not ready". A cycle is the interval between two pulses of the cycle-start strobe. The clock that carries a strobe belongs to the cycle that is ending.

Top module: `pstage_fault_sup`

## Requirements
- R1: `hs_off_o` rises only after `ocp_pos_i` has been sampled high on BLANK_CYC consecutive clocks (default 8). It goes high on the clock after the last of those samples. A shorter pulse has no effect on any output.
- R2: Once high, `hs_off_o` stays high until a clock where `cyc_start_i` is sampled high and the filtered trip is inactive. It clears on that clock.
- R3: A cycle counts as an over-current cycle if the filtered trip was active on any of its clocks. After OCP_CNT (default 10) such cycles in a row, the over-current fault becomes active. It stays active while the count sits saturated. It clears at the end of the first cycle with no trip.
- R4: Positive over-current never asserts `ls_off_o`, and it never holds the high side off beyond the rule in R2.
- R5: `ocp_neg_i` sampled high while `pwm_i` is low (low-side command) sets `ls_off_o` on the next clock. `ocp_neg_i` sampled while `pwm_i` is high is ignored.
- R6: The low-side lockout lasts exactly NOCP_CYC clocks (default 50, 200 ns at 250 MHz) and then releases. During the lockout `ocp_neg_i` is not monitored. Monitoring resumes after release, so a negative trip that is still present locks again one clock later.
- R7: `pwm_i` sampled high during the lockout ends it on the next clock, whatever the timer holds.
- R8: The over-temperature fault is set by `ot_high_i`. It is cleared only by `ot_clear_i` while `ot_high_i` is low. It never affects `hs_off_o` or `ls_off_o`.
- R9: `flag_o` is registered. It equals `ready_i` AND (over-current fault OR over-temperature fault), one clock after those are sampled. While `ready_i` is low, `flag_o` is low.
- R10: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ocp_pos_i | input | 1 | Positive over-current comparator |
| ocp_neg_i | input | 1 | Negative over-current comparator |
| ot_high_i | input | 1 | Temperature above upper threshold |
| ot_clear_i | input | 1 | Temperature below lower threshold |
| pwm_i | input | 1 | PWM level, 1 = high-side command, 0 = low-side command |
| ready_i | input | 1 | Power-up complete |
| cyc_start_i | input | 1 | One-clock pulse at the start of each switching cycle |
| hs_off_o | output | 1 | Force high-side gate off |
| ls_off_o | output | 1 | Force low-side gate off |
| flag_o | output | 1 | Fault / power-ready flag (low = not ready) |

## Verification
A blanking counter that is off by one moves the rise of `hs_off_o` by a clock, which a test pulse of exactly BLANK_CYC-1 samples exposes at once. A consecutive-cycle counter that fails to reset or to saturate shows up at `flag_o` only at the strobe boundaries, two clocks after the tenth or the clean cycle. So those checks sample around each strobe. A lockout timer error changes the clock on which `ls_off_o` falls, and the relock clock that follows shows whether monitoring resumed. Temperature hysteresis errors appear at `flag_o` within two clocks of a clear or set pulse.

// File: rtl/psf_pkg.sv
package psf_pkg;
  typedef struct packed {
    logic ocp;
    logic ot;
  } fault_src_t;

  function automatic logic any_fault(input fault_src_t s);
    return s.ocp | s.ot;
  endfunction
endpackage

// File: rtl/psf_blank_filter.sv
module psf_blank_filter #(
  parameter int BLANK_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic trip_o
);
  logic trip_q, trip_d;

  generate
    if (BLANK_CYC <= 1) begin : g_direct
      always_comb trip_d = raw_i;
    end else begin : g_count
      localparam int BW = $clog2(BLANK_CYC);
      localparam logic [BW-1:0] LAST = BW'(BLANK_CYC - 1);
      logic [BW-1:0] cnt_q, cnt_d;

      always_comb begin
        cnt_d  = cnt_q;
        trip_d = 1'b0;
        if (!raw_i) begin
          cnt_d = '0;
        end else begin
          trip_d = (cnt_q == LAST);
          if (cnt_q != LAST) cnt_d = cnt_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trip_q <= 1'b0;
    else        trip_q <= trip_d;
  end

  assign trip_o = trip_q;
endmodule

// File: rtl/psf_ocp_track.sv
module psf_ocp_track #(
  parameter int OCP_CNT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_i,
  input  logic cyc_start_i,
  output logic hs_off_o,
  output logic ocp_flag_o
);
  localparam int CW = $clog2(OCP_CNT + 1);
  localparam logic [CW-1:0] CMAX = CW'(OCP_CNT);

  logic          hs_off_q, hs_off_d;
  logic          evt_q, evt_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    hs_off_d = hs_off_q;
    if (trip_i)           hs_off_d = 1'b1;
    else if (cyc_start_i) hs_off_d = 1'b0;
  end

  always_comb begin
    evt_d = evt_q;
    cnt_d = cnt_q;
    if (cyc_start_i) begin
      evt_d = 1'b0;
      if (evt_q | trip_i) begin
        if (cnt_q != CMAX) cnt_d = cnt_q + 1'b1;
      end else begin
        cnt_d = '0;
      end
    end else if (trip_i) begin
      evt_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_off_q <= 1'b0;
      evt_q    <= 1'b0;
      cnt_q    <= '0;
    end else begin
      hs_off_q <= hs_off_d;
      evt_q    <= evt_d;
      cnt_q    <= cnt_d;
    end
  end

  assign hs_off_o   = hs_off_q;
  assign ocp_flag_o = (cnt_q == CMAX);
endmodule

// File: rtl/psf_nocp_lock.sv
module psf_nocp_lock #(
  parameter int NOCP_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic neg_i,
  input  logic pwm_i,
  output logic ls_off_o
);
  localparam int TW = (NOCP_CYC > 2) ? $clog2(NOCP_CYC) : 1;
  localparam logic [TW-1:0] TLAST = TW'(NOCP_CYC - 1);

  logic          lock_q, lock_d;
  logic [TW-1:0] tmr_q, tmr_d;

  always_comb begin
    lock_d = lock_q;
    tmr_d  = tmr_q;
    if (!lock_q) begin
      if (neg_i && !pwm_i) begin
        lock_d = 1'b1;
        tmr_d  = '0;
      end
    end else if (pwm_i) begin
      lock_d = 1'b0;
    end else if (tmr_q == TLAST) begin
      lock_d = 1'b0;
    end else begin
      tmr_d = tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      tmr_q  <= '0;
    end else begin
      lock_q <= lock_d;
      tmr_q  <= tmr_d;
    end
  end

  assign ls_off_o = lock_q;
endmodule

// File: rtl/psf_ot_hyst.sv
module psf_ot_hyst (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_i,
  input  logic clr_i,
  output logic ot_o
);
  logic ot_q, ot_d;

  always_comb begin
    ot_d = ot_q;
    if (hi_i)       ot_d = 1'b1;
    else if (clr_i) ot_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ot_q <= 1'b0;
    else        ot_q <= ot_d;
  end

  assign ot_o = ot_q;
endmodule

// File: rtl/pstage_fault_sup.sv
module pstage_fault_sup #(
  parameter int BLANK_CYC = 8,
  parameter int OCP_CNT   = 10,
  parameter int NOCP_CYC  = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ocp_pos_i,
  input  logic ocp_neg_i,
  input  logic ot_high_i,
  input  logic ot_clear_i,
  input  logic pwm_i,
  input  logic ready_i,
  input  logic cyc_start_i,
  output logic hs_off_o,
  output logic ls_off_o,
  output logic flag_o
);
  import psf_pkg::*;

  logic       trip;
  fault_src_t src;
  logic       flag_q, flag_d;

  psf_blank_filter #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk(clk), .rst_n(rst_n), .raw_i(ocp_pos_i), .trip_o(trip)
  );

  psf_ocp_track #(.OCP_CNT(OCP_CNT)) u_ocp (
    .clk(clk), .rst_n(rst_n), .trip_i(trip), .cyc_start_i(cyc_start_i),
    .hs_off_o(hs_off_o), .ocp_flag_o(src.ocp)
  );

  psf_nocp_lock #(.NOCP_CYC(NOCP_CYC)) u_nocp (
    .clk(clk), .rst_n(rst_n), .neg_i(ocp_neg_i), .pwm_i(pwm_i),
    .ls_off_o(ls_off_o)
  );

  psf_ot_hyst u_ot (
    .clk(clk), .rst_n(rst_n), .hi_i(ot_high_i), .clr_i(ot_clear_i),
    .ot_o(src.ot)
  );

  always_comb flag_d = ready_i & any_fault(src);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/psf_checker.sv
module psf_checker #(
  parameter int NOCP_CYC = 50
) (
  input logic clk,
  input logic rst_n,
  input logic ocp_pos_i,
  input logic ocp_neg_i,
  input logic ot_high_i,
  input logic pwm_i,
  input logic ready_i,
  input logic cyc_start_i,
  input logic hs_off_o,
  input logic ls_off_o,
  input logic flag_o
);
  localparam int LW = $clog2(NOCP_CYC + 2);
  logic [LW-1:0] lock_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lock_len <= '0;
    else if (ls_off_o) lock_len <= (lock_len == LW'(NOCP_CYC + 1)) ? lock_len : lock_len + 1'b1;
    else               lock_len <= '0;
  end

  a_r1_trip_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_off_o) |-> $past(ocp_pos_i));
  a_r2_release_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_off_o) |-> $past(cyc_start_i));
  a_r5_lock_needs_neg: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_off_o) |-> $past(ocp_neg_i && !pwm_i));
  a_r6_lock_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    lock_len <= LW'(NOCP_CYC));
  a_r7_pwm_ends_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_off_o && pwm_i) |=> !ls_off_o);
  a_r8_ot_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_high_i && ready_i) |=> ##1 (flag_o || !$past(ready_i)));
  a_r9_not_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_i |=> !flag_o);
endmodule

bind pstage_fault_sup psf_checker #(.NOCP_CYC(NOCP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ocp_pos_i(ocp_pos_i), .ocp_neg_i(ocp_neg_i),
  .ot_high_i(ot_high_i), .pwm_i(pwm_i), .ready_i(ready_i),
  .cyc_start_i(cyc_start_i), .hs_off_o(hs_off_o), .ls_off_o(ls_off_o),
  .flag_o(flag_o)
);

// File: tb/pstage_fault_sup_test.sv
module pstage_fault_sup_test;
  localparam int BLANK = 8;
  localparam int NCNT  = 10;
  localparam int NLOCK = 50;

  logic clk = 1'b0;
  logic rst_n, ocp_pos, ocp_neg, ot_high, ot_clear, pwm, ready, cyc_start;
  logic hs_off, ls_off, flag;
  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;

  always #2 clk = ~clk;

  pstage_fault_sup #(.BLANK_CYC(BLANK), .OCP_CNT(NCNT), .NOCP_CYC(NLOCK)) uut (
    .clk(clk), .rst_n(rst_n), .ocp_pos_i(ocp_pos), .ocp_neg_i(ocp_neg),
    .ot_high_i(ot_high), .ot_clear_i(ot_clear), .pwm_i(pwm), .ready_i(ready),
    .cyc_start_i(cyc_start), .hs_off_o(hs_off), .ls_off_o(ls_off), .flag_o(flag)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ocp_pos = 0; ocp_neg = 0; ot_high = 0; ot_clear = 0;
    pwm = 0; ready = 1; cyc_start = 0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic strobe();
    cyc_start = 1'b1; tick(1); cyc_start = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ocp_pos = 1; ocp_neg = 1; ot_high = 1; ready = 1;
    tick(3);
    chk("R10 hs_off", hs_off, 0);
    chk("R10 ls_off", ls_off, 0);
    chk("R10 flag", flag, 0);
  endtask

  task automatic t_blank();
    do_reset();
    ocp_pos = 1; tick(BLANK - 1); ocp_pos = 0; tick(3);
    chk("R1 short pulse ignored", hs_off, 0);
    ocp_pos = 1; tick(BLANK);
    chk("R1 not yet after blank", hs_off, 0);
    tick(1);
    chk("R1 forced off", hs_off, 1);
    chk("R4 low side untouched", ls_off, 0);
    strobe();
    chk("R2 held while trip active", hs_off, 1);
    ocp_pos = 0; tick(2);
    chk("R2 held until strobe", hs_off, 1);
    strobe();
    chk("R2 released at strobe", hs_off, 0);
  endtask

  task automatic t_count();
    do_reset();
    ocp_pos = 1; tick(BLANK + 2);
    for (int i = 0; i < NCNT - 1; i++) begin strobe(); tick(3); end
    chk("R3 no flag after 9 cycles", flag, 0);
    strobe(); tick(1);
    chk("R3 flag after 10 cycles", flag, 1);
    strobe(); tick(2);
    chk("R3 saturated stays", flag, 1);
    chk("R4 no low-side override", ls_off, 0);
    ocp_pos = 0; tick(2);
    strobe(); tick(2);
    chk("R3 flag held for cycle with trip", flag, 1);
    strobe(); tick(1);
    chk("R3 cleared by clean cycle", flag, 0);
    ocp_pos = 1; tick(BLANK + 2); strobe(); tick(2);
    chk("R3 count restarted", flag, 0);
  endtask

  task automatic t_nocp();
    do_reset();
    pwm = 1; ocp_neg = 1; tick(2);
    chk("R5 ignored with pwm high", ls_off, 0);
    ocp_neg = 0; pwm = 0; tick(1);
    ocp_neg = 1; tick(1);
    chk("R5 lockout set", ls_off, 1);
    tick(NLOCK - 1);
    chk("R6 still locked at last clock", ls_off, 1);
    tick(1);
    chk("R6 released by timer", ls_off, 0);
    tick(1);
    chk("R6 relock after monitoring resumes", ls_off, 1);
    ocp_neg = 0; tick(5);
    pwm = 1; tick(1);
    chk("R7 high-side command ends lock", ls_off, 0);
    chk("R4 high side untouched", hs_off, 0);
  endtask

  task automatic t_ot();
    do_reset();
    ot_high = 1; tick(1); ot_high = 0; tick(2);
    chk("R8 warning set", flag, 1);
    chk("R8 no hs override", hs_off, 0);
    chk("R8 no ls override", ls_off, 0);
    tick(5);
    chk("R8 held without clear", flag, 1);
    ot_high = 1; ot_clear = 1; tick(3);
    chk("R8 clear ignored while high", flag, 1);
    ot_high = 0; tick(2); ot_clear = 0;
    chk("R8 cleared", flag, 0);
    ot_high = 1; tick(1); ot_high = 0;
    ready = 0; tick(2);
    chk("R9 low while not ready", flag, 0);
    ready = 1; tick(1);
    chk("R9 one clock after ready", flag, 1);
  endtask

  initial begin
    t_reset();
    t_blank();
    t_count();
    t_nocp();
    t_ot();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule